// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry/Overflow Update

This unit performs the five bit-shift and bit-rotate operations of a 16-bit processor datapath: rotate left, rotate right, logical left shift, logical right shift and arithmetic right shift. Each operation works on either a byte or a word operand. The count is either the constant one or the full 8-bit value of a count register. The unit computes the new operand value and new carry and overflow flags. The caller supplies the current flag word. All other flag bits are passed back unchanged.

A one-cycle start strobe captures the request. On the next rising edge the unit registers the following outputs:

- the result;
- the merged flag word;
- a pair of flag-write enables, so the register file updates only the flags that changed;
- the number of processor cycles the operation costs.

When the count is zero, nothing is rewritten. The operand comes back as it was, the flag word comes back as it was, and both write enables are low.

Top module: `srf_unit`

## Requirements
- R1: `valid_o` is high for exactly the one cycle after each cycle in which `start_i` was high, and low otherwise. `result_o`, `flags_o`, `flag_we_o` and `cycles_o` change only on that edge and hold their values between strobes.
- R2: `fn_i` selects the operation: 0 rotate left, 1 rotate right, 4 shift left, 5 logical shift right, 7 arithmetic shift right. Codes 2, 3 and 6 return the width-masked operand, return `flags_i` unchanged and set `flag_we_o` to 0.
- R3: The count is 1 when `by_cl_i` is 0, and the full 8-bit `cl_i` when it is 1. Rotates move the data by the count modulo the operand width.
- R4: A zero count returns the width-masked operand, returns `flags_i` unchanged and sets `flag_we_o` to 0.
- R5: Rotate left sets carry to the original operand bit at index W-1-((n-1) mod W). Overflow is the top bit of (original XOR result).
- R6: Rotate right sets carry to the original operand bit at index (n-1) mod W. Overflow is the top bit of (original XOR result).
- R7: Logical shifts fill with zeros, and a count of W or more gives a zero result. Carry is the last bit shifted out, which is 0 when n > W. For the left shift, overflow is the result's top bit XOR carry. For the right shift, overflow is the original top bit.
- R8: The arithmetic right shift fills with the sign bit, so a count of W or more gives all copies of the sign bit. Carry is the last bit shifted out, which is the sign bit when n ≥ W. Overflow is 0.
- R9: In the flag word, carry is bit 0 and overflow is bit 11. Every other bit of `flags_o` equals `flags_i`. For a supported operation with a nonzero count, `flag_we_o[0]` (carry) and `flag_we_o[1]` (overflow) are both 1.
- R10: Byte mode (`wide_i`=0) uses only operand bits 7:0, takes W=8, and drives `result_o[15:8]` to zero.
- R11: `cycles_o` is 2 for the count-of-one form. For the count-register form it is 8 + 4·`cl_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, captures all inputs |
| fn_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = word operand, 0 = byte operand |
| by_cl_i | input | 1 | 1 = count from `cl_i`, 0 = count of one |
| cl_i | input | 8 | Count register value |
| opnd_i | input | 16 | Operand |
| flags_i | input | 16 | Current flag word |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 16 | Shifted or rotated value |
| flags_o | output | 16 | Updated flag word |
| flag_we_o | output | 2 | Write enables: bit 0 carry, bit 1 overflow |
| cycles_o | output | 11 | Processor cycle cost |

## Verification
Every result of this unit is due one rising edge after the strobe: the result, the flag word, the write enables and the cycle cost all arrive together with `valid_o`. The bench drives each request on a falling edge and reads all outputs on the next falling edge, half a period after the capture edge. On every falling edge it also compares `valid_o` with the strobe its model saw at the preceding rising edge. During idle cycles it re-reads the held outputs to confirm that they do not move between strobes.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int DATA_W   = 16;
    localparam int HALF_W   = DATA_W / 2;
    localparam int CNT_W    = 8;
    localparam int AMT_W    = $clog2(DATA_W);
    localparam int CYC_W    = 11;
    localparam int CYC_ONE  = 2;
    localparam int CYC_BASE = 8;
    localparam int CYC_STEP = 4;
    localparam int CF_POS   = 0;
    localparam int OF_POS   = 11;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAR = 3'd7
    } sr_op_e;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [CNT_W-1:0] n;
        logic             zero;
        logic [AMT_W-1:0] amt;
        logic [CYC_W-1:0] cycles;
    } cnt_info_t;

    typedef struct packed {
        word_t res;
        logic  cf;
        logic  of;
        logic  touch;
    } core_out_t;

    function automatic word_t fit(word_t v, logic wide);
        return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    endfunction

    function automatic logic top_bit(word_t v, logic wide);
        return wide ? v[DATA_W-1] : v[HALF_W-1];
    endfunction
endpackage

// File: rtl/srf_count.sv
module srf_count
    import srf_pkg::*;
(
    input  logic             by_cl,
    input  logic [CNT_W-1:0] cl_val,
    input  logic             wide,
    output cnt_info_t        info
);
    logic [CNT_W-1:0] n;

    always_comb begin
        n           = by_cl ? cl_val : CNT_W'(1);
        info.n      = n;
        info.zero   = (n == '0);
        info.amt    = wide ? n[AMT_W-1:0] : {1'b0, n[AMT_W-2:0]};
        info.cycles = by_cl ? (CYC_W'(CYC_BASE) + CYC_W'(CYC_STEP) * CYC_W'(n))
                            : CYC_W'(CYC_ONE);
    end
endmodule

// File: rtl/srf_core.sv
module srf_core
    import srf_pkg::*;
(
    input  logic [2:0] fn,
    input  logic       wide,
    input  word_t      opnd,
    input  cnt_info_t  cnt,
    output core_out_t  out
);
    localparam int DBL_W = 2 * DATA_W;
    localparam int EXT_W = DATA_W + 1;

    word_t                   a;
    logic [DBL_W-1:0]        rot_src, rl_dbl, rr_dbl, shl_ext;
    logic [EXT_W-1:0]        shr_ext;
    logic signed [EXT_W-1:0] sar_src, sar_ext;
    word_t                   rol_r, ror_r;

    always_comb begin
        a       = fit(opnd, wide);
        // Doubled copy: a shift of the pair yields the rotated value in one slice
        rot_src = wide ? {a, a} : {{DATA_W{1'b0}}, a[HALF_W-1:0], a[HALF_W-1:0]};
        rl_dbl  = rot_src << cnt.amt;
        rr_dbl  = rot_src >> cnt.amt;
        rol_r   = wide ? rl_dbl[DBL_W-1:DATA_W] : {{HALF_W{1'b0}}, rl_dbl[DATA_W-1:HALF_W]};
        ror_r   = wide ? rr_dbl[DATA_W-1:0]     : {{HALF_W{1'b0}}, rr_dbl[HALF_W-1:0]};
        // Extended shifts keep the last bit out as a guard bit
        shl_ext = {{DATA_W{1'b0}}, a} << cnt.n;
        shr_ext = {a, 1'b0} >> cnt.n;
        sar_src = wide ? {a, 1'b0} : {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0], 1'b0};
        sar_ext = sar_src >>> cnt.n;

        out.res   = a;
        out.cf    = 1'b0;
        out.of    = 1'b0;
        out.touch = 1'b0;
        if (!cnt.zero) begin
            case (fn)
                OP_ROL: begin
                    out.res   = rol_r;
                    out.cf    = rol_r[0];
                    out.of    = top_bit(a ^ rol_r, wide);
                    out.touch = 1'b1;
                end
                OP_ROR: begin
                    out.res   = ror_r;
                    out.cf    = top_bit(ror_r, wide);
                    out.of    = top_bit(a ^ ror_r, wide);
                    out.touch = 1'b1;
                end
                OP_SHL: begin
                    out.res   = fit(shl_ext[DATA_W-1:0], wide);
                    out.cf    = wide ? shl_ext[DATA_W] : shl_ext[HALF_W];
                    out.of    = top_bit(out.res, wide) ^ out.cf;
                    out.touch = 1'b1;
                end
                OP_SHR: begin
                    out.res   = shr_ext[EXT_W-1:1];
                    out.cf    = shr_ext[0];
                    out.of    = top_bit(a, wide);
                    out.touch = 1'b1;
                end
                OP_SAR: begin
                    out.res   = fit(sar_ext[EXT_W-1:1], wide);
                    out.cf    = sar_ext[0];
                    out.of    = 1'b0;
                    out.touch = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srf_unit.sv
module srf_unit
    import srf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [2:0]          fn_i,
    input  logic                wide_i,
    input  logic                by_cl_i,
    input  logic [CNT_W-1:0]    cl_i,
    input  logic [DATA_W-1:0]   opnd_i,
    input  logic [DATA_W-1:0]   flags_i,
    output logic                valid_o,
    output logic [DATA_W-1:0]   result_o,
    output logic [DATA_W-1:0]   flags_o,
    output logic [1:0]          flag_we_o,
    output logic [CYC_W-1:0]    cycles_o
);
    cnt_info_t cnt;
    core_out_t core;
    word_t     merged;

    srf_count u_count (
        .by_cl  (by_cl_i),
        .cl_val (cl_i),
        .wide   (wide_i),
        .info   (cnt)
    );

    srf_core u_core (
        .fn   (fn_i),
        .wide (wide_i),
        .opnd (opnd_i),
        .cnt  (cnt),
        .out  (core)
    );

    always_comb begin
        merged = flags_i;
        if (core.touch) begin
            merged[CF_POS] = core.cf;
            merged[OF_POS] = core.of;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            result_o  <= '0;
            flags_o   <= '0;
            flag_we_o <= '0;
            cycles_o  <= '0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                result_o  <= core.res;
                flags_o   <= merged;
                flag_we_o <= {2{core.touch}};
                cycles_o  <= cnt.cycles;
            end
        end
    end
endmodule

// File: rtl/srf_unit_chk.sv
module srf_unit_chk
    import srf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [2:0]          fn_i,
    input logic                wide_i,
    input logic                by_cl_i,
    input logic [CNT_W-1:0]    cl_i,
    input logic [DATA_W-1:0]   flags_i,
    input logic                valid_o,
    input logic [DATA_W-1:0]   result_o,
    input logic [DATA_W-1:0]   flags_o,
    input logic [1:0]          flag_we_o,
    input logic [CYC_W-1:0]    cycles_o
);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~((DATA_W'(1) << CF_POS) | (DATA_W'(1) << OF_POS));

    // R1
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);
    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && (fn_i == 3'd2 || fn_i == 3'd3 || fn_i == 3'd6) |=> flag_we_o == 2'b00);
    // R4
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && by_cl_i && cl_i == '0 |=> flag_we_o == 2'b00 && flags_o == $past(flags_i));
    // R8
    sar_of_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && fn_i == 3'd7 && !(by_cl_i && cl_i == '0) |=> !flags_o[OF_POS]);
    // R9
    keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ((flags_o ^ $past(flags_i)) & KEEP_MASK) == '0);
    // R10
    byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && !wide_i |=> result_o[DATA_W-1:HALF_W] == '0);
    // R11
    one_cost_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && !by_cl_i |=> cycles_o == CYC_W'(CYC_ONE));
endmodule

bind srf_unit srf_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .fn_i      (fn_i),
    .wide_i    (wide_i),
    .by_cl_i   (by_cl_i),
    .cl_i      (cl_i),
    .flags_i   (flags_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o),
    .cycles_o  (cycles_o)
);

// File: tb/srf_unit_bench.sv
module srf_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  fn_i = '0;
    logic        wide_i = 1'b0;
    logic        by_cl_i = 1'b0;
    logic [7:0]  cl_i = '0;
    logic [15:0] opnd_i = '0;
    logic [15:0] flags_i = '0;
    logic        valid_o;
    logic [15:0] result_o;
    logic [15:0] flags_o;
    logic [1:0]  flag_we_o;
    logic [10:0] cycles_o;

    int n_checks = 0;
    int n_errors = 0;
    logic start_seen = 1'b0;
    int exp_res = 0, exp_fl = 0, exp_we = 0, exp_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srf_unit u_srf_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .fn_i(fn_i), .wide_i(wide_i),
        .by_cl_i(by_cl_i), .cl_i(cl_i), .opnd_i(opnd_i), .flags_i(flags_i),
        .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o),
        .flag_we_o(flag_we_o), .cycles_o(cycles_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Bit-serial behavioural model: one step per count position
    task automatic model(input int fn, input int wide, input int by_cl, input int cl,
                         input int opnd, input int flags);
        int w = wide ? 16 : 8;
        int n = by_cl ? cl : 1;
        int msk = (1 << w) - 1;
        int v = opnd & msk;
        int orig = v;
        int c = 0;
        int o = 0;
        bit sup = (fn == 0 || fn == 1 || fn == 4 || fn == 5 || fn == 7);
        if (sup) begin
            for (int i = 0; i < n; i++) begin
                int hi = (v >> (w - 1)) & 1;
                int lo = v & 1;
                case (fn)
                    0: begin c = hi; v = ((v << 1) | hi) & msk; end
                    1: begin c = lo; v = (v >> 1) | (lo << (w - 1)); end
                    4: begin c = hi; v = (v << 1) & msk; end
                    5: begin c = lo; v = v >> 1; end
                    default: begin c = lo; v = (v >> 1) | (hi << (w - 1)); end
                endcase
            end
            case (fn)
                0, 1: o = ((orig ^ v) >> (w - 1)) & 1;
                4: o = ((v >> (w - 1)) & 1) ^ c;
                5: o = (orig >> (w - 1)) & 1;
                default: o = 0;
            endcase
        end
        exp_res = v;
        if (sup && n != 0) begin
            exp_fl = (flags & ~32'h0801) | c | (o << 11);
            exp_we = 3;
        end else begin
            exp_fl = flags;
            exp_we = 0;
        end
        exp_cyc = by_cl ? 8 + 4 * cl : 2;
    endtask

    task automatic run_op(input int fn, input int wide, input int by_cl, input int cl,
                          input int opnd, input int flags, input string tag);
        @(negedge clk);
        fn_i = 3'(fn); wide_i = wide[0]; by_cl_i = by_cl[0]; cl_i = 8'(cl);
        opnd_i = 16'(opnd); flags_i = 16'(flags); start_i = 1'b1;
        model(fn, wide, by_cl, cl, opnd, flags);
        @(negedge clk);
        start_i = 1'b0;
        chk(result_o == 16'(exp_res), {tag, " result"}, int'(result_o), exp_res);
        chk(flags_o == 16'(exp_fl), {tag, " flags"}, int'(flags_o), exp_fl);
        chk(flag_we_o == 2'(exp_we), {tag, " flag_we"}, int'(flag_we_o), exp_we);
        chk(cycles_o == 11'(exp_cyc), {tag, " cycles"}, int'(cycles_o), exp_cyc);
    endtask

    // R1: valid follows the strobe seen at the previous rising edge, every clock
    always @(posedge clk) start_seen <= rst ? 1'b0 : start_i;
    always @(negedge clk) begin
        if (!rst) chk(valid_o == start_seen, "R1 valid timing", int'(valid_o), int'(start_seen));
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result_o == 16'h0 && flag_we_o == 2'b00 && cycles_o == 11'd0,
            "reset state", int'(result_o), 0);

        run_op(0, 0, 0, 0, 16'h0081, 16'h0000, "R5 rol byte by one");
        run_op(0, 1, 1, 17, 16'h8001, 16'h08D5, "R5 R3 rol word by 17");
        run_op(0, 1, 1, 5, 16'h1234, 16'h0000, "R5 rol word by 5");
        run_op(1, 0, 1, 3, 16'h00A5, 16'h0000, "R6 ror byte by 3");
        run_op(1, 1, 1, 16, 16'hC003, 16'hFFFF, "R6 R3 ror word by 16");
        run_op(0, 1, 1, 0, 16'hBEEF, 16'hFFFF, "R4 zero count rol");
        run_op(5, 0, 1, 0, 16'h00F0, 16'h0801, "R4 zero count shr");
        run_op(4, 1, 1, 16, 16'h0001, 16'h0000, "R7 shl word by width");
        run_op(4, 1, 1, 20, 16'hFFFF, 16'h0801, "R7 shl word past width");
        run_op(5, 0, 1, 8, 16'h0080, 16'h0000, "R7 shr byte by width");
        run_op(5, 1, 0, 0, 16'h8001, 16'h0000, "R7 shr word by one");
        run_op(7, 0, 1, 200, 16'h0080, 16'h0800, "R8 sar byte large count");
        run_op(7, 1, 1, 4, 16'h8010, 16'h0000, "R8 sar word by 4");
        run_op(6, 1, 1, 3, 16'h1234, 16'h0801, "R2 unsupported code");
        run_op(2, 0, 0, 0, 16'hAB12, 16'h0000, "R2 unsupported byte");
        run_op(4, 0, 0, 0, 16'hFF40, 16'hF7FE, "R10 R9 shl byte upper ignored");
        run_op(1, 1, 1, 255, 16'h0F0F, 16'h0000, "R11 longest cost");

        // R1: outputs hold while idle
        repeat (4) begin
            @(negedge clk);
            chk(result_o == 16'(exp_res), "R1 held result", int'(result_o), exp_res);
        end

        for (int k = 0; k < 300; k++) begin
            int codes[5] = '{0, 1, 4, 5, 7};
            run_op(codes[$urandom_range(0, 4)], int'($urandom_range(0, 1)),
                   int'($urandom_range(0, 1)), int'($urandom_range(0, 40)),
                   int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF), "R3 random mix");
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule